// File: doc/BRIEF.md
# Timer Event Output Arbiter

This block holds four registered event bits that are driven by a timer. Each bit can be changed by two sources. The first is a pair of per-event strobes from software, one to set and one to clear. The second is four timer channels. Each channel presents one request per cycle. A request names a target event and asks for one of four actions on it: clear, set, toggle or pulse. On every clock edge the block works out a single winning update for each event and registers the result.

Channel requests are packed onto flat buses with a fixed width per channel. A pulse drives its event high for one cycle and then drops it again, unless a new update arrives in that next cycle. Software strobes override every channel request. An event whose set and clear strobes arrive together gets no software update in that cycle, so channel requests for that event still apply.

Top module: `tmr_event_arbiter`

## Requirements
- R1: While reset is asserted (rst_n low), all four event outputs are low and no pulse is pending. With no requests after reset, the outputs stay low.
- R2: A software set strobe on an event, without its clear strobe, makes that event high after the next clock edge, whatever the channels request for it.
- R3: A software clear strobe on an event, without its set strobe, makes that event low after the next clock edge, whatever the channels request for it.
- R4: When the set and clear strobes of an event are both high in the same cycle, both are ignored, and the event is updated by the channel requests alone.
- R5: Channel c uses bit c of req_valid, bits [2c+1:2c] of req_event as the target index, and bits [2c+1:2c] of req_action as the action code. The codes are 0 = clear, 1 = set, 2 = toggle, 3 = pulse. A request whose valid bit is low has no effect.
- R6: When several channels target the same event in one cycle, the winner is the action with the highest priority, in the order clear, set, toggle, pulse. The channel number plays no part in this choice.
- R7: A winning toggle makes the event the inverse of its registered value.
- R8: A winning pulse makes the event high for exactly one cycle. If the event gets no update in the following cycle, it returns low.
- R9: An event that no request targets keeps its value, unless it is finishing a pulse (R8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low reset |
| sw_set | input | 4 | Software set strobe, one bit per event |
| sw_clr | input | 4 | Software clear strobe, one bit per event |
| req_valid | input | 4 | Request valid, one bit per channel |
| req_event | input | 8 | Target event index, 2 bits per channel |
| req_action | input | 8 | Action code, 2 bits per channel |
| evt_out | output | 4 | Registered event bits |

## Verification
The only internal state beyond the outputs is the pending-pulse flag of each event. If that flag is wrong, the fault shows one cycle after a pulse: the event either stays high or drops while other traffic is present. If the priority choice is wrong, evt_out differs right after the edge that follows the conflicting requests. The bench therefore compares all four event bits after every single edge. It uses a model that scans the actions in order of priority, and it drives many overlapping requests at random. This exposes any fault within one cycle.

// File: rtl/tea_pkg.sv
package tea_pkg;

  // Number of bits used for each action code on the request bus.
  localparam int ACT_W = 2;

  // Action codes carried on the request bus.
  typedef enum logic [ACT_W-1:0] {
    ACT_CLR = 2'd0,
    ACT_SET = 2'd1,
    ACT_TOG = 2'd2,
    ACT_PLS = 2'd3
  } tea_act_e;

  // The update that is applied to one event in a cycle.
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MSET = 3'd1,
    SEL_MCLR = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_SET  = 3'd4,
    SEL_TOG  = 3'd5,
    SEL_PLS  = 3'd6
  } tea_sel_e;

  // Picks the winning update for one event.
  // Software strobes come first, unless set and clear arrive together.
  // After them, the channel actions are taken in fixed priority order.
  function automatic tea_sel_e tea_pick(input logic mset, input logic mclr,
                                        input logic hclr, input logic hset,
                                        input logic htog, input logic hpls);
    tea_sel_e s;
    if (mset && !mclr)      s = SEL_MSET;
    else if (mclr && !mset) s = SEL_MCLR;
    else if (hclr)          s = SEL_CLR;
    else if (hset)          s = SEL_SET;
    else if (htog)          s = SEL_TOG;
    else if (hpls)          s = SEL_PLS;
    else                    s = SEL_NONE;
    return s;
  endfunction

  // Returns {next event value, next pending-pulse flag}.
  function automatic logic [1:0] tea_apply(input tea_sel_e sel,
                                           input logic cur, input logic pend);
    logic [1:0] r;
    case (sel)
      SEL_MSET: r = 2'b10;
      SEL_MCLR: r = 2'b00;
      SEL_CLR:  r = 2'b00;
      SEL_SET:  r = 2'b10;
      SEL_TOG:  r = {~cur, 1'b0};
      SEL_PLS:  r = 2'b11;
      default:  r = pend ? 2'b00 : {cur, 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tea_req_decode.sv
module tea_req_decode
  import tea_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_EV  = 4,
  parameter int IDX_W   = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic [NUM_CH-1:0]       req_valid,
  input  logic [NUM_CH*IDX_W-1:0] req_event,
  input  logic [NUM_CH*ACT_W-1:0] req_action,
  output logic [NUM_EV-1:0]       hit_clr,
  output logic [NUM_EV-1:0]       hit_set,
  output logic [NUM_EV-1:0]       hit_tog,
  output logic [NUM_EV-1:0]       hit_pls
);

  // For each event, one flag per action code. A flag is high when any
  // valid channel requests that action on that event.
  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    localparam logic [IDX_W-1:0] EIDX = IDX_W'(e);
    logic h_clr, h_set, h_tog, h_pls;

    always_comb begin
      h_clr = 1'b0;
      h_set = 1'b0;
      h_tog = 1'b0;
      h_pls = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (req_valid[c] && (req_event[c*IDX_W +: IDX_W] == EIDX)) begin
          case (tea_act_e'(req_action[c*ACT_W +: ACT_W]))
            ACT_CLR: h_clr = 1'b1;
            ACT_SET: h_set = 1'b1;
            ACT_TOG: h_tog = 1'b1;
            default: h_pls = 1'b1;
          endcase
        end
      end
    end

    assign hit_clr[e] = h_clr;
    assign hit_set[e] = h_set;
    assign hit_tog[e] = h_tog;
    assign hit_pls[e] = h_pls;
  end

endmodule

// File: rtl/tea_event_cell.sv
module tea_event_cell
  import tea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hit_clr,
  input  logic hit_set,
  input  logic hit_tog,
  input  logic hit_pls,
  output logic evt
);

  logic       pend_q;
  logic       evt_q;
  tea_sel_e   sel;
  logic [1:0] nxt;

  // Named wires for the assertions below.
  logic sw_take;     // a single software strobe is present
  logic any_hit;     // some channel targets this event
  logic sw_conflict; // set and clear strobes arrive together

  assign sw_take     = sw_set ^ sw_clr;
  assign sw_conflict = sw_set & sw_clr;
  assign any_hit     = hit_clr | hit_set | hit_tog | hit_pls;

  assign sel = tea_pick(sw_set, sw_clr, hit_clr, hit_set, hit_tog, hit_pls);
  assign nxt = tea_apply(sel, evt_q, pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      evt_q  <= nxt[1];
      pend_q <= nxt[0];
    end
  end

  assign evt = evt_q;

  assert_sw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && !sw_clr) |=> evt_q);

  assert_sw_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !sw_set) |=> !evt_q);

  assert_conflict_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_conflict && hit_clr) |=> !evt_q);

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_take && hit_clr) |=> !evt_q);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_take && !hit_clr && hit_set) |=> evt_q);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_take && !hit_clr && !hit_set && hit_tog) |=> (evt_q != $past(evt_q)));

  assert_pulse_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_take && !hit_clr && !hit_set && !hit_tog && hit_pls) |=> evt_q);

  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sw_take && !any_hit) |=> !evt_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !sw_take && !any_hit) |=> $stable(evt_q));

endmodule

// File: rtl/tmr_event_arbiter.sv
module tmr_event_arbiter
  import tea_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_EV = 4,
  localparam int IDX_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_EV-1:0]       sw_set,
  input  logic [NUM_EV-1:0]       sw_clr,
  input  logic [NUM_CH-1:0]       req_valid,
  input  logic [NUM_CH*IDX_W-1:0] req_event,
  input  logic [NUM_CH*ACT_W-1:0] req_action,
  output logic [NUM_EV-1:0]       evt_out
);

  logic [NUM_EV-1:0] hit_clr, hit_set, hit_tog, hit_pls;

  tea_req_decode #(
    .NUM_CH (NUM_CH),
    .NUM_EV (NUM_EV),
    .IDX_W  (IDX_W)
  ) u_decode (
    .req_valid  (req_valid),
    .req_event  (req_event),
    .req_action (req_action),
    .hit_clr    (hit_clr),
    .hit_set    (hit_set),
    .hit_tog    (hit_tog),
    .hit_pls    (hit_pls)
  );

  for (genvar e = 0; e < NUM_EV; e++) begin : g_cell
    tea_event_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_set  (sw_set[e]),
      .sw_clr  (sw_clr[e]),
      .hit_clr (hit_clr[e]),
      .hit_set (hit_set[e]),
      .hit_tog (hit_tog[e]),
      .hit_pls (hit_pls[e]),
      .evt     (evt_out[e])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (evt_out == '0);
    end
  end

endmodule

// File: tb/tmr_event_arbiter_test.sv
`timescale 1ns/1ps
module tmr_event_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] sw_set = '0, sw_clr = '0;
  logic [3:0] req_valid = '0;
  logic [7:0] req_event = '0, req_action = '0;
  logic [3:0] evt_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [3:0] m_out  = '0;
  logic [3:0] m_pend = '0;
  logic [3:0] e_out, e_pend;

  always #2 clk = ~clk;

  tmr_event_arbiter uut (
    .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .sw_clr(sw_clr),
    .req_valid(req_valid), .req_event(req_event), .req_action(req_action),
    .evt_out(evt_out)
  );

  // Model: the software strobe wins unless both strobes are present.
  // Otherwise the actions are scanned from the highest priority code order:
  // 0 clear, 1 set, 2 toggle, 3 pulse.
  function automatic void predict();
    for (int e = 0; e < 4; e++) begin
      int win = -1;
      if (sw_set[e] != sw_clr[e]) begin
        e_out[e] = sw_set[e];
        e_pend[e] = 1'b0;
      end else begin
        for (int pri = 0; pri < 4 && win < 0; pri++)
          for (int c = 0; c < 4; c++)
            if (req_valid[c] && req_event[2*c +: 2] == e && req_action[2*c +: 2] == pri)
              win = pri;
        case (win)
          0: begin e_out[e] = 1'b0; e_pend[e] = 1'b0; end
          1: begin e_out[e] = 1'b1; e_pend[e] = 1'b0; end
          2: begin e_out[e] = !m_out[e]; e_pend[e] = 1'b0; end
          3: begin e_out[e] = 1'b1; e_pend[e] = 1'b1; end
          default: begin
            e_out[e] = m_pend[e] ? 1'b0 : m_out[e];
            e_pend[e] = 1'b0;
          end
        endcase
      end
    end
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    n_checks++;
    if (evt_out !== exp) begin
      n_fails++;
      $display("FAIL %s: evt_out=%b expected %b", tag, evt_out, exp);
    end
  endtask

  task automatic step(input string tag);
    predict();
    @(posedge clk);
    #1;
    check(tag, e_out);
    m_out = e_out;
    m_pend = e_pend;
  endtask

  task automatic idle();
    sw_set = '0; sw_clr = '0; req_valid = '0; req_event = '0; req_action = '0;
  endtask

  task automatic req(input int c, input int ev, input int act);
    req_valid[c] = 1'b1;
    req_event[2*c +: 2] = ev[1:0];
    req_action[2*c +: 2] = act[1:0];
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: evt_out=%b expected run completion", evt_out);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 4'b0000);
    rst_n = 1'b1;
    step("R1 idle after reset");

    // R2: software set beats a channel clear
    sw_set[0] = 1'b1; req(2, 0, 0);
    step("R2 set over channel clear");
    if (evt_out[0] !== 1'b1) begin n_checks++; n_fails++; $display("FAIL R2: bit0=%b expected 1", evt_out[0]); end
    idle();
    // R3: software clear beats a channel set
    sw_clr[0] = 1'b1; req(1, 0, 1);
    step("R3 clear over channel set");
    idle();
    // R4: both strobes ignored, channel set applies
    sw_set[1] = 1'b1; sw_clr[1] = 1'b1; req(3, 1, 1);
    step("R4 conflict lets channel set through");
    idle();
    sw_set[1] = 1'b1; sw_clr[1] = 1'b1;
    step("R4 conflict alone holds");
    idle();
    // R5: invalid request ignored
    req(0, 2, 1); req_valid[0] = 1'b0;
    step("R5 invalid request ignored");
    idle();
    // R5: channel 3 field position
    req(3, 2, 1);
    step("R5 channel 3 set event 2");
    idle();
    // R6: clear from ch3 beats set from ch0
    req(0, 2, 1); req(3, 2, 0);
    step("R6 clear beats set");
    idle();
    req(1, 2, 2); req(2, 2, 1);
    step("R6 set beats toggle");
    idle();
    req(0, 3, 3); req(1, 3, 2);
    step("R6 toggle beats pulse");
    idle();
    step("R6 no pulse tail after toggle win");
    // R7: toggle twice
    req(2, 3, 2);
    step("R7 toggle 1->0");
    step("R7 toggle 0->1");
    idle();
    req(0, 3, 0);
    step("R7 prep clear");
    idle();
    // R8: pulse high one cycle then low
    req(1, 3, 3);
    step("R8 pulse high");
    idle();
    step("R8 pulse returns low");
    step("R9 hold after pulse");
    // R8: repeated pulse keeps high
    req(2, 0, 3);
    step("R8 pulse first");
    step("R8 pulse again");
    idle();
    step("R8 pulse end");
    // R1: reset during a pulse
    req(0, 1, 3);
    step("R8 pulse before reset");
    idle();
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset clears", 4'b0000);
    m_out = '0; m_pend = '0;
    rst_n = 1'b1;
    step("R1 no pending pulse after reset");

    // Random mix, R9 covered by whole-vector compare
    for (int i = 0; i < 600; i++) begin
      idle();
      for (int e = 0; e < 4; e++) begin
        sw_set[e] = ($urandom % 8) == 0;
        sw_clr[e] = ($urandom % 8) == 0;
      end
      for (int c = 0; c < 4; c++)
        if (($urandom % 3) != 0) req(c, $urandom % 4, $urandom % 4);
      step("R6 random");
    end
    idle();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule